// File: doc/BRIEF.md
# UART Register Front-End

This block is the programmable face of a simple serial port. A 32-bit register bus with a single-cycle access reaches a small bank of word registers: a status word, a receive data word, a baud divisor, three control words and a guard/prescale word. On the other side sits a byte-wide character link. Bytes written for transmission go out on a one-cycle strobe. Received bytes come in through a valid/ready handshake.

Bit serialization, baud timing and framing are handled elsewhere. Here a transmit counts as finished at once. The front-end gates incoming bytes on the control enables. It keeps the receive-full and transmit flags and drives one level-sensitive interrupt line. It also applies the two-mode write rule of the status word.

Read data, the bus error flag, `rx_ready` and the interrupt are combinational from the current register state and the current access. Every register update takes effect at the clock edge that samples the access.

Top module: `usart_reg_front`

## Requirements
- R1: After reset the status word reads 0x000000C0 (bits 6 and 7 set), every other register reads 0, `irq` and `tx_valid` are low and `rx_ready` is high.
- R2: Registers sit at byte offsets 0x00 status, 0x04 data, 0x08 baud divisor, 0x0C control 1, 0x10 control 2, 0x14 control 3, 0x18 guard/prescale. The divisor, control 2, control 3 and guard words store all 32 written bits, read them back unchanged, and have no other effect.
- R3: An access to any other byte offset of the 0x400-byte window reads 0 and changes no register. This includes offsets that are not a multiple of 4. `bus_err` is high in the cycle of such an access.
- R4: `irq` is high exactly when one of status bits 5 (receive full), 6 (transmit complete) or 7 (transmit empty) is set together with the same bit of control 1. It follows the register state in the cycle after the change.
- R5: A byte offered on the receive link is discarded when control 1 bit 13 (unit enable) or bit 2 (receive enable) is clear. The data register and status bit 5 are left unchanged.
- R6: With both enables set, a byte taken on the handshake is stored in the data register and sets status bit 5. `rx_ready` is low while bit 5 is set, unless the data register is being read in that cycle.
- R7: A read of the data register returns the stored byte in bits 9:0, with the upper bits zero, and clears status bit 5.
- R8: A status write whose value is at most 0x3FF replaces the status word with that value, with bit 7 forced to 1.
- R9: A status write whose value exceeds 0x3FF ANDs the value into the current status word.
- R10: A data-register write below 0xF000 pulses `tx_valid` for one cycle in the following cycle, carrying bits 7:0 of the value on `tx_byte`, and sets status bit 6. A write of 0xF000 or more has no effect.
- R11: When a byte arrives in the same cycle as a data-register read, the read returns the old byte, the new byte is accepted and stored, and status bit 5 stays set.
- R12: Receive gating uses the control 1 value held before the current cycle. A byte arriving in the cycle that writes control 1 is judged by the old enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte offset within the register window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| bus_err | output | 1 | Access to an unmapped offset |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | BYTE_W | Byte to transmit |
| rx_valid | input | 1 | Receive byte offered |
| rx_byte | input | BYTE_W | Received byte |
| rx_ready | output | 1 | Receive handshake ready |
| irq | output | 1 | Level interrupt |

## Verification
Any wrong status bit reaches the ports in the next cycle. It shows on `irq` once the matching enable is set, on `rx_ready` for the receive-full bit, and on a status read. A mis-gated receive byte shows as a changed data word or a set bit 5 on the next read, or as a lost byte when a read and an arrival share a cycle. A broken write rule shows on the read back of the status word in the cycle right after the write, and a broken transmit path shows as a missing or extra `tx_valid` in that cycle.

// File: rtl/usart_pkg.sv
package usart_pkg;

  localparam int REG_W      = 32;
  localparam int REG_STRIDE = 4;

  typedef enum logic [2:0] {
    RI_STAT  = 3'd0,
    RI_DATA  = 3'd1,
    RI_BAUD  = 3'd2,
    RI_CTL1  = 3'd3,
    RI_CTL2  = 3'd4,
    RI_CTL3  = 3'd5,
    RI_GUARD = 3'd6
  } reg_idx_e;

  localparam int NUM_REGS  = 7;
  localparam int FIRST_CFG = int'(RI_BAUD);
  localparam int NUM_CFG   = NUM_REGS - FIRST_CFG;

  // status bits and the same-position interrupt enables in control 1
  localparam int BIT_RXFULL  = 5;
  localparam int BIT_TXDONE  = 6;
  localparam int BIT_TXEMPTY = 7;
  // control 1 enables
  localparam int BIT_RXEN    = 2;
  localparam int BIT_UNITEN  = 13;

  localparam logic [REG_W-1:0] STAT_RESET   = 32'h0000_00C0;
  localparam logic [REG_W-1:0] STAT_REPL_MAX = 32'h0000_03FF;
  localparam logic [REG_W-1:0] TX_LIMIT     = 32'h0000_F000;
  localparam logic [REG_W-1:0] DATA_RD_MASK = 32'h0000_03FF;

  localparam logic [REG_W-1:0] IRQ_SRC_MASK =
    (REG_W'(1) << BIT_RXFULL) | (REG_W'(1) << BIT_TXDONE) | (REG_W'(1) << BIT_TXEMPTY);

  // status word after a bus write: replace mode or AND mode
  function automatic logic [REG_W-1:0] stat_after_write(input logic [REG_W-1:0] cur,
                                                        input logic [REG_W-1:0] val);
    if (val <= STAT_REPL_MAX) return val | (REG_W'(1) << BIT_TXEMPTY);
    return cur & val;
  endfunction

  function automatic logic irq_level(input logic [REG_W-1:0] stat,
                                     input logic [REG_W-1:0] ctl1);
    return |(stat & ctl1 & IRQ_SRC_MASK);
  endfunction

  function automatic logic rx_enabled(input logic [REG_W-1:0] ctl1);
    return ctl1[BIT_UNITEN] & ctl1[BIT_RXEN];
  endfunction

endpackage

// File: rtl/usart_addr_dec.sv
module usart_addr_dec #(
  parameter int ADDR_W = 10,
  parameter int N_REGS = usart_pkg::NUM_REGS
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_REGS-1:0] sel,
  output logic              hit
);
  for (genvar g = 0; g < N_REGS; g++) begin : g_sel
    assign sel[g] = (addr == ADDR_W'(g * usart_pkg::REG_STRIDE));
  end
  assign hit = |sel;
endmodule

// File: rtl/usart_cfg_bank.sv
module usart_cfg_bank #(
  parameter int N_CFG = usart_pkg::NUM_CFG,
  parameter int W     = usart_pkg::REG_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_CFG-1:0]    wr_sel,
  input  logic [W-1:0]        wdata,
  output logic [W-1:0]        q [N_CFG]
);
  for (genvar g = 0; g < N_CFG; g++) begin : g_reg
    logic [W-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         r <= '0;
      else if (wr_sel[g]) r <= wdata;
    end
    assign q[g] = r;
  end
endmodule

// File: rtl/usart_status.sv
module usart_status #(
  parameter int W = usart_pkg::REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stat_wr,
  input  logic         tx_fire,
  input  logic         data_rd,
  input  logic         rx_take,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] stat_q
);
  import usart_pkg::*;

  logic [W-1:0] stat_d;

  // order: bus write, transmit event, read clear, then a new byte
  always_comb begin
    stat_d = stat_q;
    if (stat_wr) stat_d = stat_after_write(stat_q, wdata);
    if (tx_fire) stat_d[BIT_TXDONE] = 1'b1;
    if (data_rd) stat_d[BIT_RXFULL] = 1'b0;
    if (rx_take) stat_d[BIT_RXFULL] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= STAT_RESET;
    else        stat_q <= stat_d;
  end
endmodule

// File: rtl/usart_rx_path.sv
module usart_rx_path #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_full,
  input  logic              data_rd,
  input  logic              rx_en,
  output logic              rx_ready,
  output logic              rx_take,
  output logic              rx_drop,
  output logic [BYTE_W-1:0] data_q
);
  logic shake;

  assign rx_ready = ~rx_full | data_rd;
  assign shake    = rx_valid & rx_ready;
  assign rx_take  = shake & rx_en;
  assign rx_drop  = shake & ~rx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (rx_take) data_q <= rx_byte;
  end
endmodule

// File: rtl/usart_tx_port.sv
module usart_tx_port #(
  parameter int BYTE_W = 8,
  parameter int W      = usart_pkg::REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic [W-1:0]      wdata,
  output logic              tx_fire,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte
);
  assign tx_fire = data_wr && (wdata < usart_pkg::TX_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_valid <= tx_fire;
      if (tx_fire) tx_byte <= wdata[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/usart_reg_front.sv
module usart_reg_front #(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rx_ready,
  output logic              irq
);
  import usart_pkg::*;

  localparam int W = REG_W;

  logic [NUM_REGS-1:0] sel;
  logic                hit;
  logic                stat_wr, data_wr, data_rd;
  logic                tx_fire, rx_take, rx_drop, rx_en;
  logic [W-1:0]        stat_q;
  logic [W-1:0]        cfg_q [NUM_CFG];
  logic [W-1:0]        ctl1_q;
  logic [BYTE_W-1:0]   data_q;
  logic [NUM_CFG-1:0]  cfg_wr;

  usart_addr_dec #(.ADDR_W(ADDR_W), .N_REGS(NUM_REGS)) dec_i (
    .addr(bus_addr), .sel(sel), .hit(hit)
  );

  assign stat_wr = bus_wr & sel[RI_STAT];
  assign data_wr = bus_wr & sel[RI_DATA];
  assign data_rd = bus_rd & sel[RI_DATA];
  assign cfg_wr  = {NUM_CFG{bus_wr}} & sel[NUM_REGS-1:FIRST_CFG];

  usart_cfg_bank #(.N_CFG(NUM_CFG), .W(W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_sel(cfg_wr), .wdata(bus_wdata), .q(cfg_q)
  );

  assign ctl1_q = cfg_q[int'(RI_CTL1) - FIRST_CFG];
  assign rx_en  = rx_enabled(ctl1_q);

  usart_tx_port #(.BYTE_W(BYTE_W), .W(W)) tx_i (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .wdata(bus_wdata),
    .tx_fire(tx_fire), .tx_valid(tx_valid), .tx_byte(tx_byte)
  );

  usart_rx_path #(.BYTE_W(BYTE_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_full(stat_q[BIT_RXFULL]), .data_rd(data_rd), .rx_en(rx_en),
    .rx_ready(rx_ready), .rx_take(rx_take), .rx_drop(rx_drop), .data_q(data_q)
  );

  usart_status #(.W(W)) stat_i (
    .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr), .tx_fire(tx_fire),
    .data_rd(data_rd), .rx_take(rx_take), .wdata(bus_wdata), .stat_q(stat_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel[RI_STAT]) bus_rdata = stat_q;
      if (sel[RI_DATA]) bus_rdata = W'(data_q) & DATA_RD_MASK;
      for (int i = 0; i < NUM_CFG; i++)
        if (sel[FIRST_CFG + i]) bus_rdata = cfg_q[i];
    end
  end

  assign bus_err = (bus_rd | bus_wr) & ~hit;
  assign irq     = irq_level(stat_q, ctl1_q);

endmodule

// File: rtl/usart_reg_front_chk.sv
module usart_reg_front_chk #(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic              bus_err,
  input logic              tx_valid,
  input logic [BYTE_W-1:0] tx_byte,
  input logic              rx_valid,
  input logic [BYTE_W-1:0] rx_byte,
  input logic              rx_ready,
  input logic              irq,
  input logic [31:0]       stat_q,
  input logic [BYTE_W-1:0] data_q,
  input logic              rx_take,
  input logic              rx_drop
);
  logic at_stat, at_data, mapped;
  assign at_stat = (bus_addr == ADDR_W'(0));
  assign at_data = (bus_addr == ADDR_W'(4));
  assign mapped  = (bus_addr < ADDR_W'(28)) && (bus_addr[1:0] == 2'b00);

  assert_unmapped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !mapped) |-> (bus_rdata == 32'h0 && bus_err));

  assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(bus_wr || rx_take));

  assert_drop_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> $stable(data_q));

  assert_ready_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[5] && !(bus_rd && at_data)) |-> !rx_ready);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && at_data && !rx_take) |=> !stat_q[5]);

  assert_replace_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && at_stat && bus_wdata <= 32'h3FF && !rx_take)
      |=> (stat_q == ($past(bus_wdata) | 32'h80)));

  assert_and_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && at_stat && bus_wdata > 32'h3FF && !rx_take)
      |=> (stat_q == ($past(stat_q) & $past(bus_wdata))));

  assert_tx_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && at_data && bus_wdata < 32'hF000)
      |=> (tx_valid && tx_byte == $past(bus_wdata[BYTE_W-1:0]) && stat_q[6]));

  assert_tx_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && at_data && bus_wdata < 32'hF000) |=> !tx_valid);

  assert_take_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take |=> (stat_q[5] && data_q == $past(rx_byte)));

endmodule

bind usart_reg_front usart_reg_front_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_err(bus_err),
  .tx_valid(tx_valid), .tx_byte(tx_byte), .rx_valid(rx_valid), .rx_byte(rx_byte),
  .rx_ready(rx_ready), .irq(irq), .stat_q(stat_q), .data_q(data_q),
  .rx_take(rx_take), .rx_drop(rx_drop)
);

// File: tb/usart_reg_front_tb_top.sv
module usart_reg_front_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int WATCHDOG_CYC = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_rdata;
  logic          bus_err;
  logic          tx_valid;
  logic [7:0]    tx_byte;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_byte = '0;
  logic          rx_ready;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usart_reg_front #(.ADDR_W(AW), .BYTE_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_ready(rx_ready), .irq(irq)
  );

  // {is_write, offset, data or expected read}
  localparam int NV = 21;
  localparam logic [42:0] VEC [NV] = '{
    {1'b1, 10'h000, 32'h0000_0000},  // R8 replace, bit 7 forced
    {1'b0, 10'h000, 32'h0000_0080},
    {1'b1, 10'h000, 32'h0000_03FF},  // R8 upper bound of replace mode
    {1'b0, 10'h000, 32'h0000_03FF},
    {1'b1, 10'h000, 32'hFFFF_FF3F},  // R9 AND mode
    {1'b0, 10'h000, 32'h0000_033F},
    {1'b1, 10'h000, 32'h0000_00C0},
    {1'b0, 10'h000, 32'h0000_00C0},
    {1'b1, 10'h008, 32'h1234_ABCD},  // R2 divisor
    {1'b0, 10'h008, 32'h1234_ABCD},
    {1'b1, 10'h010, 32'hDEAD_BEEF},  // R2 control 2
    {1'b0, 10'h010, 32'hDEAD_BEEF},
    {1'b1, 10'h014, 32'h0000_0FFF},  // R2 control 3
    {1'b0, 10'h014, 32'h0000_0FFF},
    {1'b1, 10'h018, 32'h0000_A5A5},  // R2 guard
    {1'b0, 10'h018, 32'h0000_A5A5},
    {1'b1, 10'h01C, 32'hFFFF_FFFF},  // R3 first unmapped word
    {1'b0, 10'h01C, 32'h0000_0000},
    {1'b1, 10'h3FC, 32'h0000_0005},  // R3 last word of window
    {1'b0, 10'h3FC, 32'h0000_0000},
    {1'b0, 10'h006, 32'h0000_0000}   // R3 unaligned
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1; d = bus_rdata; e = bus_err;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] b, output logic rdy);
    @(negedge clk);
    rx_byte = b; rx_valid = 1'b1;
    #1; rdy = rx_ready;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  function automatic logic is_mapped(input logic [AW-1:0] a);
    return (a <= AW'(24)) && (a % 4 == 0);
  endfunction

  initial begin : watchdog
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] r;
    logic        e, rdy;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 tx_valid", {31'b0, tx_valid}, 0);
    check("R1 rx_ready", {31'b0, rx_ready}, 1);
    bus_read(10'h000, r, e); check("R1 status", r, 32'hC0);
    bus_read(10'h004, r, e); check("R1 data", r, 0);
    bus_read(10'h00C, r, e); check("R1 control1", r, 0);
    bus_read(10'h018, r, e); check("R1 guard", r, 0);

    // table: R2 R3 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [AW-1:0] a;
      logic [31:0]   d;
      a = VEC[i][41:32];
      d = VEC[i][31:0];
      if (VEC[i][42]) bus_write(a, d);
      else begin
        bus_read(a, r, e);
        check($sformatf("R2/R3/R8/R9 table row %0d data", i), r, d);
        check($sformatf("R3 table row %0d err", i), {31'b0, e}, {31'b0, !is_mapped(a)});
      end
    end

    // R4 interrupt from transmit-empty and transmit-complete
    bus_write(10'h00C, 32'h80); #1;
    check("R4 irq on bit7 enable", {31'b0, irq}, 1);
    bus_write(10'h00C, 32'h40); #1;
    check("R4 irq on bit6 enable", {31'b0, irq}, 1);
    bus_write(10'h000, 32'h0); #1;
    check("R4 irq low with bit6 clear", {31'b0, irq}, 0);

    // R10 transmit
    bus_write(10'h004, 32'h1A5); #1;
    check("R10 tx_valid", {31'b0, tx_valid}, 1);
    check("R10 tx_byte", {24'b0, tx_byte}, 32'hA5);
    check("R4 irq after transmit", {31'b0, irq}, 1);
    @(negedge clk); #1;
    check("R10 single pulse", {31'b0, tx_valid}, 0);
    bus_write(10'h000, 32'h0);
    bus_write(10'h004, 32'hF000); #1;
    check("R10 no pulse at limit", {31'b0, tx_valid}, 0);
    bus_read(10'h000, r, e);
    check("R10 bit6 untouched at limit", r & 32'h40, 0);

    // R5 gating: unit enable alone, receive enable alone
    bus_write(10'h00C, 32'h2000);
    rx_send(8'h33, rdy);
    bus_read(10'h000, r, e); check("R5 unit only, no full flag", r & 32'h20, 0);
    bus_write(10'h00C, 32'h0004);
    rx_send(8'h34, rdy);
    bus_read(10'h004, r, e); check("R5 data kept", r, 0);

    // R6 accept, R7 read
    bus_write(10'h00C, 32'h2024); #1;
    check("R4 irq low before byte", {31'b0, irq}, 0);
    rx_send(8'h5A, rdy); #1;
    check("R6 ready before", {31'b0, rdy}, 1);
    check("R6 ready low when full", {31'b0, rx_ready}, 0);
    check("R4 irq on receive", {31'b0, irq}, 1);
    rx_send(8'h77, rdy);
    check("R6 byte refused while full", {31'b0, rdy}, 0);
    bus_read(10'h000, r, e); check("R6 full flag", r & 32'h20, 32'h20);
    bus_read(10'h004, r, e); check("R7 data", r, 32'h5A);
    #1;
    check("R7 full cleared -> ready", {31'b0, rx_ready}, 1);
    check("R7 irq cleared", {31'b0, irq}, 0);

    // R11 read and arrival in the same cycle
    rx_send(8'h11, rdy);
    @(negedge clk);
    bus_addr = 10'h004; bus_rd = 1'b1; rx_byte = 8'h22; rx_valid = 1'b1;
    #1;
    check("R11 old byte read", bus_rdata, 32'h11);
    check("R11 ready during read", {31'b0, rx_ready}, 1);
    @(negedge clk);
    bus_rd = 1'b0; rx_valid = 1'b0;
    bus_read(10'h000, r, e); check("R11 full flag kept", r & 32'h20, 32'h20);
    bus_read(10'h004, r, e); check("R11 new byte held", r, 32'h22);

    // R12 gating uses the control value before the write
    bus_write(10'h00C, 32'h0);
    @(negedge clk);
    bus_addr = 10'h00C; bus_wdata = 32'h2004; bus_wr = 1'b1;
    rx_byte = 8'h99; rx_valid = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; rx_valid = 1'b0;
    bus_read(10'h000, r, e); check("R12 no full flag", r & 32'h20, 0);
    bus_read(10'h004, r, e); check("R12 data unchanged", r, 32'h22);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule